// File: doc/BRIEF.md
# SIMT Warp Divergence Path Scheduler

This block follows control-flow divergence for a single warp of 32 lanes and chooses, every cycle, which control-flow path issues. It keeps a small table of independent path entries, each a lane mask and an instruction pointer. When a resolved branch splits the active lanes of the issuing path, the block keeps the taken lanes in that entry and writes the not-taken lanes into a free entry. From then on the two paths are scheduled as peers and can interleave cycle by cycle. Neither path has to run to completion before the other starts.

Branch and sync events apply to the instruction that issues in the same cycle. A path that reaches a sync instruction parks at that pointer. When every valid path is parked at the same pointer, the block folds them back into one entry holding the union of their lanes. That entry then resumes at the next pointer. Instruction fetch, execution and operand storage are outside the block. Without an event, a path's pointer simply advances by one after each issue.

Top module: `simt_path_sched`

## Requirements
- R1: After reset the table holds exactly one path, with all 32 lanes active at pointer 0, so the first issue presents pointer 0 and mask 0xFFFFFFFF.
- R2: An issue that carries no branch and no sync advances that path's pointer by one for its next issue.
- R3: A branch on which all active lanes of the issuing path agree creates no new path. The path keeps its mask and continues at the taken target if every active lane is taken, or at the not-taken target if none is; lanes outside the mask do not count.
- R4: A branch that splits the active lanes keeps the taken lanes (mask AND taken vector) in the issuing entry at the taken target. It stores the remaining active lanes at the not-taken target in the lowest-numbered free entry.
- R5: At most one path issues per cycle. `issueValid` is high only when `issueReady` is high and some path is neither free nor parked, and an issued mask is never zero.
- R6: Selection among issuable paths is round-robin over entry numbers, starting after the entry that issued last. After a split, issue therefore alternates between the two paths.
- R7: A path that issues a sync parks and does not issue again. When all valid paths are parked at one pointer, the block spends one cycle with no issue and merges them into the lowest-numbered valid entry. That entry holds the OR of their masks and resumes at the sync pointer plus one.
- R8: A split that finds no free entry sets the sticky `overflow` output. The issuing path then continues at its pointer plus one with its mask unchanged, and no path is created.
- R9: The masks of valid paths are pairwise disjoint, and their OR is always 0xFFFFFFFF.
- R10: A cycle with no issue and no merge changes no path, and branch or sync inputs in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueReady | input | 1 | Downstream can accept an instruction this cycle |
| brValid | input | 1 | The instruction issuing this cycle is a resolved branch |
| brTaken | input | 32 | Per-lane branch outcome, 1 = taken |
| brTakenIp | input | 32 | Pointer of the taken side |
| brNotTakenIp | input | 32 | Pointer of the not-taken side |
| syncValid | input | 1 | The instruction issuing this cycle is a sync point |
| issueValid | output | 1 | A path issues this cycle |
| issueIp | output | 32 | Pointer of the issuing path |
| issueMask | output | 32 | Active lanes of the issuing path, zero when nothing issues |
| overflow | output | 1 | Sticky flag: a split was dropped because the table was full |

## Verification
The assertions assume that branch and sync events never arrive together and that parked paths always meet at a common sync pointer. Without the second condition the warp deadlocks, and the merge check cannot fire. The directed scenarios steer every diverged path to one shared pointer with a coherent branch before each sync, and they raise only one event per issue. The lane-coverage invariant relies on no lane ever retiring, which holds because the block has no exit input.

// File: rtl/simt_sched_pkg.sv
package simt_sched_pkg;
  localparam int LANES   = 32;
  localparam int ENTRIES = 4;   // power of two, for round-robin wrap
  localparam int IPW     = 32;
  localparam int IDXW    = $clog2(ENTRIES);

  typedef logic [LANES-1:0] mask_t;
  typedef logic [IPW-1:0]   ip_t;
  typedef logic [IDXW-1:0]  idx_t;

  // strobes from control to the path table
  typedef struct packed {
    logic  fire;
    idx_t  sel;
    ip_t   selNextIp;
    logic  selMaskLoad;
    mask_t selNewMask;
    logic  park;
    logic  spawn;
    idx_t  spawnIdx;
    ip_t   spawnIp;
    mask_t spawnMask;
    logic  merge;
    idx_t  mergeIdx;
  } strobes_t;
endpackage

// File: rtl/simt_path_table.sv
module simt_path_table
  import simt_sched_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobes_t                      st,
  output logic [ENTRIES-1:0]            valid,
  output logic [ENTRIES-1:0]            parked,
  output logic [ENTRIES-1:0][IPW-1:0]   ipArr,
  output logic [ENTRIES-1:0][LANES-1:0] maskArr
);

  mask_t orMask;
  logic  overlap;

  always_comb begin
    orMask  = '0;
    overlap = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid[i]) begin
        overlap = overlap | (|(orMask & maskArr[i]));
        orMask  = orMask | maskArr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid   <= '0;
      parked  <= '0;
      ipArr   <= '0;
      maskArr <= '0;
      valid[0]   <= 1'b1;
      maskArr[0] <= '1;
    end else if (st.merge) begin
      for (int i = 0; i < ENTRIES; i++) begin
        parked[i] <= 1'b0;
        if (idx_t'(i) == st.mergeIdx) begin
          maskArr[i] <= orMask;
          ipArr[i]   <= ipArr[i] + ip_t'(1);
        end else begin
          valid[i] <= 1'b0;
        end
      end
    end else if (st.fire) begin
      ipArr[st.sel] <= st.selNextIp;
      if (st.selMaskLoad) maskArr[st.sel] <= st.selNewMask;
      if (st.park)        parked[st.sel]  <= 1'b1;
      if (st.spawn) begin
        valid[st.spawnIdx]   <= 1'b1;
        parked[st.spawnIdx]  <= 1'b0;
        ipArr[st.spawnIdx]   <= st.spawnIp;
        maskArr[st.spawnIdx] <= st.spawnMask;
      end
    end
  end

  // R9
  lanes_partition_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!overlap && orMask == '1));

  // R7
  merge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.merge |=> ($countones(valid) == 1));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.fire && !st.merge) |=> ($stable(ipArr) && $stable(maskArr) && $stable(valid)));

endmodule

// File: rtl/simt_path_ctrl.sv
module simt_path_ctrl
  import simt_sched_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0]            parked,
  input  logic [ENTRIES-1:0][IPW-1:0]   ipArr,
  input  logic [ENTRIES-1:0][LANES-1:0] maskArr,
  input  logic                          issueReady,
  input  logic                          brValid,
  input  mask_t                         brTaken,
  input  ip_t                           brTakenIp,
  input  ip_t                           brNotTakenIp,
  input  logic                          syncValid,
  output strobes_t                      st,
  output logic                          issueValid,
  output ip_t                           issueIp,
  output mask_t                         issueMask,
  output logic                          overflow
);

  idx_t  lastIdx, sel, cand, freeIdx, lowValid;
  logic  anyElig, hasFree, anyValid, sameIp, fire, ovfSet;
  mask_t tk, nt;
  logic [ENTRIES-1:0] elig;

  assign elig = valid & ~parked;

  // round-robin pick starting after the last issuer
  always_comb begin
    sel     = '0;
    anyElig = 1'b0;
    cand    = '0;
    for (int k = 1; k <= ENTRIES; k++) begin
      cand = idx_t'(int'(lastIdx) + k);
      if (!anyElig && elig[cand]) begin
        sel     = cand;
        anyElig = 1'b1;
      end
    end
  end

  // lowest free slot, lowest valid slot, common-pointer test
  always_comb begin
    freeIdx  = '0;
    hasFree  = 1'b0;
    lowValid = '0;
    anyValid = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin freeIdx  = idx_t'(i); hasFree  = 1'b1; end
      if (valid[i])  begin lowValid = idx_t'(i); anyValid = 1'b1; end
    end
    sameIp = 1'b1;
    for (int i = 0; i < ENTRIES; i++)
      if (valid[i] && ipArr[i] != ipArr[lowValid]) sameIp = 1'b0;
  end

  assign fire       = issueReady && anyElig;
  assign issueValid = fire;
  assign issueIp    = fire ? ipArr[sel]   : '0;
  assign issueMask  = fire ? maskArr[sel] : '0;
  assign tk         = maskArr[sel] & brTaken;
  assign nt         = maskArr[sel] & ~brTaken;

  always_comb begin
    st           = '0;
    ovfSet       = 1'b0;
    st.fire      = fire;
    st.sel       = sel;
    st.selNextIp = ipArr[sel] + ip_t'(1);
    st.merge     = anyValid && !anyElig && sameIp;
    st.mergeIdx  = lowValid;
    if (fire) begin
      if (brValid) begin
        if (tk == '0) begin
          st.selNextIp = brNotTakenIp;
        end else if (nt == '0) begin
          st.selNextIp = brTakenIp;
        end else if (hasFree) begin
          st.selNextIp   = brTakenIp;
          st.selMaskLoad = 1'b1;
          st.selNewMask  = tk;
          st.spawn       = 1'b1;
          st.spawnIdx    = freeIdx;
          st.spawnIp     = brNotTakenIp;
          st.spawnMask   = nt;
        end else begin
          ovfSet = 1'b1;
        end
      end else if (syncValid) begin
        st.park      = 1'b1;
        st.selNextIp = ipArr[sel];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastIdx  <= idx_t'(ENTRIES - 1);
      overflow <= 1'b0;
    end else begin
      if (fire)   lastIdx  <= sel;
      if (ovfSet) overflow <= 1'b1;
    end
  end

  // R5
  issue_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (issueMask != '0 && issueReady));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R7
  no_issue_on_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.merge |-> !issueValid);

endmodule

// File: rtl/simt_path_sched.sv
module simt_path_sched
  import simt_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueReady,
  input  logic              brValid,
  input  logic [LANES-1:0]  brTaken,
  input  logic [IPW-1:0]    brTakenIp,
  input  logic [IPW-1:0]    brNotTakenIp,
  input  logic              syncValid,
  output logic              issueValid,
  output logic [IPW-1:0]    issueIp,
  output logic [LANES-1:0]  issueMask,
  output logic              overflow
);

  strobes_t                      st;
  logic [ENTRIES-1:0]            valid, parked;
  logic [ENTRIES-1:0][IPW-1:0]   ipArr;
  logic [ENTRIES-1:0][LANES-1:0] maskArr;

  simt_path_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .valid(valid), .parked(parked),
    .ipArr(ipArr), .maskArr(maskArr), .issueReady(issueReady),
    .brValid(brValid), .brTaken(brTaken), .brTakenIp(brTakenIp),
    .brNotTakenIp(brNotTakenIp), .syncValid(syncValid), .st(st),
    .issueValid(issueValid), .issueIp(issueIp), .issueMask(issueMask),
    .overflow(overflow)
  );

  simt_path_table u_table (
    .clk(clk), .rstN(rstN), .st(st), .valid(valid), .parked(parked),
    .ipArr(ipArr), .maskArr(maskArr)
  );

endmodule

// File: tb/simt_path_sched_bench.sv
module simt_path_sched_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueReady = 1'b0, brValid = 1'b0, syncValid = 1'b0;
  logic [31:0] brTaken = '0, brTakenIp = '0, brNotTakenIp = '0;
  logic        issueValid, overflow;
  logic [31:0] issueIp, issueMask;

  int checks = 0, errors = 0;
  logic        gV, gOvf;
  logic [31:0] gIp, gMask;

  always #10 clk = ~clk;

  simt_path_sched u_simt_path_sched (
    .clk(clk), .rstN(rstN), .issueReady(issueReady), .brValid(brValid),
    .brTaken(brTaken), .brTakenIp(brTakenIp), .brNotTakenIp(brNotTakenIp),
    .syncValid(syncValid), .issueValid(issueValid), .issueIp(issueIp),
    .issueMask(issueMask), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one cycle's inputs, capture outputs before the next edge
  task automatic step(input logic rdy, input logic br, input logic [31:0] tk,
                      input logic [31:0] tip, input logic [31:0] nip, input logic sy);
    @(negedge clk);
    issueReady = rdy; brValid = br; brTaken = tk;
    brTakenIp = tip; brNotTakenIp = nip; syncValid = sy;
    #1;
    gV = issueValid; gIp = issueIp; gMask = issueMask; gOvf = overflow;
  endtask

  task automatic plain();
    step(1'b1, 1'b0, '0, '0, '0, 1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; issueReady = 1'b0; brValid = 1'b0; syncValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testResetAndAdvance();
    doReset();
    plain();
    chk("R1 valid", {63'd0, gV}, 64'd1);
    chk("R1 ip", {32'd0, gIp}, 64'd0);
    chk("R1 mask", {32'd0, gMask}, 64'hFFFFFFFF);
    chk("R1 overflow", {63'd0, gOvf}, 64'd0);
    plain();
    chk("R2 ip+1", {32'd0, gIp}, 64'd1);
    plain();
    chk("R2 ip+2", {32'd0, gIp}, 64'd2);
  endtask

  task automatic testCoherent();
    doReset();
    step(1'b1, 1'b1, 32'hFFFFFFFF, 32'd100, 32'd200, 1'b0);
    plain();
    chk("R3 all taken ip", {32'd0, gIp}, 64'd100);
    chk("R3 all taken mask", {32'd0, gMask}, 64'hFFFFFFFF);
    step(1'b1, 1'b1, 32'h0, 32'd300, 32'd400, 1'b0);
    plain();
    chk("R3 none taken ip", {32'd0, gIp}, 64'd400);
    plain();
    chk("R3 still single path", {32'd0, gIp}, 64'd401);
  endtask

  task automatic testSplitAndSync();
    doReset();
    step(1'b1, 1'b1, 32'h0000FFFF, 32'd100, 32'd200, 1'b0);
    plain();
    chk("R4 new path ip", {32'd0, gIp}, 64'd200);
    chk("R4 new path mask", {32'd0, gMask}, 64'hFFFF0000);
    plain();
    chk("R6 alternate ip", {32'd0, gIp}, 64'd100);
    chk("R4 taken mask", {32'd0, gMask}, 64'h0000FFFF);
    // e1 at 201: coherent with its own lanes (none taken)
    step(1'b1, 1'b1, 32'h0000FFFF, 32'd500, 32'd300, 1'b0);
    chk("R6 alternate back", {32'd0, gIp}, 64'd201);
    step(1'b1, 1'b1, 32'hFFFFFFFF, 32'd300, 32'd999, 1'b0);
    chk("R6 e0 ip", {32'd0, gIp}, 64'd101);
    step(1'b1, 1'b0, '0, '0, '0, 1'b1);
    chk("R3 inactive lanes ignored ip", {32'd0, gIp}, 64'd300);
    chk("R3 inactive lanes ignored mask", {32'd0, gMask}, 64'hFFFF0000);
    step(1'b1, 1'b0, '0, '0, '0, 1'b1);
    chk("R7 other path reaches sync", {32'd0, gIp}, 64'd300);
    chk("R7 parked path not issued", {32'd0, gMask}, 64'h0000FFFF);
    plain();
    chk("R7 merge cycle idle", {63'd0, gV}, 64'd0);
    plain();
    chk("R7 merged ip", {32'd0, gIp}, 64'd301);
    chk("R7 merged mask", {32'd0, gMask}, 64'hFFFFFFFF);
    plain();
    chk("R7 single path after merge", {32'd0, gIp}, 64'd302);
  endtask

  task automatic testOverflow();
    logic [31:0] orM, andAcc;
    doReset();
    step(1'b1, 1'b1, 32'h1, 32'd10, 32'd20, 1'b0);
    step(1'b1, 1'b1, 32'h2, 32'd30, 32'd40, 1'b0);
    chk("R4 second split ip", {32'd0, gIp}, 64'd20);
    step(1'b1, 1'b1, 32'h4, 32'd50, 32'd60, 1'b0);
    chk("R4 third split ip", {32'd0, gIp}, 64'd40);
    step(1'b1, 1'b1, 32'h8, 32'd70, 32'd80, 1'b0);
    chk("R8 full table ip", {32'd0, gIp}, 64'd60);
    chk("R8 overflow low before", {63'd0, gOvf}, 64'd0);
    plain();
    chk("R8 overflow set", {63'd0, gOvf}, 64'd1);
    chk("R6 wrap to e0", {32'd0, gIp}, 64'd10);
    orM = gMask; andAcc = '0;
    plain();
    chk("R6 e1", {32'd0, gIp}, 64'd30);
    andAcc |= orM & gMask; orM |= gMask;
    plain();
    chk("R6 e2", {32'd0, gIp}, 64'd50);
    andAcc |= orM & gMask; orM |= gMask;
    plain();
    chk("R8 dropped split ip", {32'd0, gIp}, 64'd61);
    chk("R8 dropped split mask", {32'd0, gMask}, 64'hFFFFFFF8);
    andAcc |= orM & gMask; orM |= gMask;
    chk("R9 masks cover warp", {32'd0, orM}, 64'hFFFFFFFF);
    chk("R9 masks disjoint", {32'd0, andAcc}, 64'd0);
    plain();
    chk("R8 overflow sticky", {63'd0, gOvf}, 64'd1);
    chk("R5 four-path rotation", {32'd0, gIp}, 64'd11);
  endtask

  task automatic testNotReady();
    doReset();
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 32'h0000FFFF, 32'd100, 32'd200, 1'b0);
      chk("R5 no issue when not ready", {63'd0, gV}, 64'd0);
    end
    step(1'b0, 1'b0, '0, '0, '0, 1'b1);
    plain();
    chk("R10 ip unchanged", {32'd0, gIp}, 64'd0);
    chk("R10 mask unchanged", {32'd0, gMask}, 64'hFFFFFFFF);
    plain();
    chk("R10 no split happened", {32'd0, gIp}, 64'd1);
  endtask

  initial begin
    testResetAndAdvance();
    testCoherent();
    testSplitAndSync();
    testOverflow();
    testNotReady();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule